// File: doc/BRIEF.md
# Adaptive Current-Sense Blanking Timer

This block masks the current-sense comparator of a motor bridge for a short window after every start of the drive phase, so switching transients cannot end the drive phase early. The masking window is also the shortest drive time the bridge can see. The window is not fixed. It is looked up from the current sine-table step code and the 2-bit torque scaling code, which are captured together with the drive-start pulse. Lower step codes and lower torque settings give shorter windows, so the minimum on-time shrinks when the target current is small.

The default parameters assume a 10 MHz clock. The four window lengths are 18, 15, 12 and 9 cycles, and step codes run from 1 to 16. The controller that uses this block sends a one-cycle `drive_start` pulse each time it turns the bridge on. It reads `trip_out` to end the drive phase, and it can watch `blank_active` to see when the window is open.

The control is a three-state machine:
- **IDLE**: no drive phase is running and the comparator is ignored.
- **BLANK**: the window is open, the cycle counter is running and the comparator is ignored.
- **ARMED**: the window has closed and the comparator is passed to the output.

The transitions are named as follows:
- **T_START**: IDLE to BLANK on `drive_start`.
- **T_EXPIRE**: BLANK to ARMED when the counter reaches zero.
- **T_RESTART**: BLANK or ARMED back to BLANK on `drive_start`, with a freshly loaded length.
- **T_TRIP**: ARMED to IDLE when the comparator is high.

`drive_start` takes priority over every other transition.

Top module: `sense_blank_timer`

## Requirements
- R1: After reset `blank_active` and `trip_out` are both 0, and the machine is in IDLE.
- R2: A `drive_start` pulse sampled at a clock edge makes `blank_active` 1 from that edge on, for exactly N clock cycles, where N is the selected window length. After that the machine is ARMED.
- R3: `trip_out` is 0 in every cycle in which `blank_active` is 1, whatever `sense_raw` does.
- R4: With `torque_sel` = 2'b00, step codes 9..16 give 18 cycles, 5..8 give 15, 3..4 give 12 and 1..2 give 9.
- R5: With `torque_sel` = 2'b01, step codes 5..16 give 15 cycles, 3..4 give 12 and 1..2 give 9.
- R6: With `torque_sel` = 2'b10, step codes 9..16 give 15 cycles, 5..8 give 12 and 1..4 give 9.
- R7: With `torque_sel` = 2'b11, step codes 9..16 give 12 cycles and 1..8 give 9.
- R8: Step code 0 is treated as step code 1. Step codes 17..31 on the 5-bit input are treated as 16.
- R9: `step_code` and `torque_sel` are captured only at the `drive_start` edge. Changing them while the window is open does not change its length.
- R10: A `drive_start` that arrives while the window is open, or while the machine is ARMED, restarts the window with the length looked up at that pulse.
- R11: In ARMED, `trip_out` follows `sense_raw` in the same cycle. The cycle after a trip, the machine is in IDLE and `trip_out` is 0.
- R12: In IDLE, `sense_raw` has no effect: `trip_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (10 MHz for the default lengths) |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_start | input | 1 | One-cycle pulse marking the start of a drive phase |
| sense_raw | input | 1 | Unmasked current-sense comparator output |
| step_code | input | 5 | Sine-table step code, 1..16 (0 is read as 1, anything above 16 as 16) |
| torque_sel | input | 2 | Torque scaling: 00 full, 01 three quarters, 10 half, 11 quarter |
| trip_out | output | 1 | Masked trip: comparator high while ARMED |
| blank_active | output | 1 | High while the blanking window is open |

## Verification
The bench sweeps every value of the 5-bit step code against all four torque codes. For each pair it measures the window in cycles and compares it with the table. A wrong band boundary, a swapped torque column, or an off-by-one in the counter each show up as a length mismatch. The out-of-range step codes are part of the sweep, so a design that did not clamp them would return a short or random window.

The bench holds the comparator high during every window, so a mask leak shows up at once as an early trip. It also scrambles the codes right after each pulse, so a design that reads them continuously instead of capturing them at the pulse gets the wrong length. A pulse sent in the middle of a window must restart the count with the new length; a design that ignored it would finish the old 18-cycle window. Finally, the bench checks that a trip returns the machine to IDLE and that a high comparator in IDLE never produces a trip, which catches a machine that stays ARMED or starts unmasked.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    // Control states of the blanking machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ARMED = 2'd2
    } sbt_state_e;

    // Window tiers, longest first
    typedef enum logic [1:0] {
        TIER_LONG  = 2'd0,
        TIER_MID   = 2'd1,
        TIER_SHORT = 2'd2,
        TIER_MIN   = 2'd3
    } sbt_tier_e;

    // Torque scaling codes
    typedef enum logic [1:0] {
        TQ_FULL = 2'b00,
        TQ_3Q   = 2'b01,
        TQ_HALF = 2'b10,
        TQ_1Q   = 2'b11
    } sbt_torque_e;

endpackage

// File: rtl/sbt_tier_lookup.sv
module sbt_tier_lookup
    import sbt_pkg::*;
#(
    parameter int STEP_W   = 5,
    parameter int STEP_MAX = 16
) (
    input  logic [STEP_W-1:0] step_code,
    input  logic [1:0]        torque_sel,
    output sbt_tier_e         tier
);

    // Band edges are derived from the top step: upper half, upper quarter, upper eighth
    localparam logic [STEP_W-1:0] TOP_CODE = STEP_W'(STEP_MAX);
    localparam logic [STEP_W-1:0] EDGE_HI  = STEP_W'(STEP_MAX / 2);
    localparam logic [STEP_W-1:0] EDGE_MID = STEP_W'(STEP_MAX / 4);
    localparam logic [STEP_W-1:0] EDGE_LO  = STEP_W'(STEP_MAX / 8);

    logic [STEP_W-1:0] eff_step;
    logic [1:0]        band;     // 0 = upper half ... 3 = lowest eighth
    logic [1:0]        band_inc;
    sbt_torque_e       tq;

    // Clamp the step code into 1..STEP_MAX (R8)
    always_comb begin
        if (step_code == '0)
            eff_step = STEP_W'(1);
        else if (step_code > TOP_CODE)
            eff_step = TOP_CODE;
        else
            eff_step = step_code;
    end

    always_comb begin
        if (eff_step > EDGE_HI)
            band = 2'd0;
        else if (eff_step > EDGE_MID)
            band = 2'd1;
        else if (eff_step > EDGE_LO)
            band = 2'd2;
        else
            band = 2'd3;
    end

    // One band shorter, saturating at the shortest band
    assign band_inc = (band == 2'd3) ? 2'd3 : band + 2'd1;
    assign tq       = sbt_torque_e'(torque_sel);

    // Map band and torque code to a window tier (R4..R7)
    always_comb begin
        unique case (tq)
            TQ_FULL: tier = sbt_tier_e'(band);
            TQ_3Q:   tier = (band == 2'd0) ? TIER_MID : sbt_tier_e'(band);
            TQ_HALF: tier = sbt_tier_e'(band_inc);
            TQ_1Q:   tier = (band == 2'd0) ? TIER_SHORT : TIER_MIN;
            default: tier = TIER_MIN;
        endcase
    end

endmodule

// File: rtl/sbt_fsm.sv
module sbt_fsm
    import sbt_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sense,
    input  logic [CNT_W-1:0] load_len,
    output logic             blank_active,
    output logic             trip
);

    sbt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // Next-state logic: a start pulse overrides every other transition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_BLANK;                                          // T_START
            ST_BLANK: if (start) state_d = ST_BLANK; else if (cnt_zero) state_d = ST_ARMED;   // T_RESTART / T_EXPIRE
            ST_ARMED: if (start) state_d = ST_BLANK; else if (sense) state_d = ST_IDLE;       // T_RESTART / T_TRIP
            default:  state_d = ST_IDLE;
        endcase
    end

    // Window counter: load length-1 on start, count down while blanking
    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = load_len - CNT_W'(1);
        else if (state_q == ST_BLANK && !cnt_zero)
            cnt_d = cnt_q - CNT_W'(1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        blank_active = 1'b0;
        trip         = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BLANK: blank_active = 1'b1;
            ST_ARMED: trip = sense;
            default:  ;
        endcase
    end

    // While the counter is above zero and no restart arrives, the window stays open
    assert_window_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && !cnt_zero && !start) |=> (state_q == ST_BLANK));

    // The counter steps down by exactly one per cycle, so a captured length cannot change
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && !cnt_zero && !start) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // The window closes into ARMED when the count is used up
    assert_expire_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && cnt_zero && !start) |=> (state_q == ST_ARMED));

    // A trip leads back to IDLE
    assert_trip_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !start) |=> (state_q == ST_IDLE && !trip));

endmodule

// File: rtl/sense_blank_timer.sv
module sense_blank_timer
    import sbt_pkg::*;
#(
    parameter int STEP_W   = 5,
    parameter int STEP_MAX = 16,
    parameter int LEN_LONG  = 18,
    parameter int LEN_MID   = 15,
    parameter int LEN_SHORT = 12,
    parameter int LEN_MIN   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_start,
    input  logic              sense_raw,
    input  logic [STEP_W-1:0] step_code,
    input  logic [1:0]        torque_sel,
    output logic              trip_out,
    output logic              blank_active
);

    localparam int CNT_W = $clog2(LEN_LONG + 1);

    sbt_tier_e        tier;
    logic [CNT_W-1:0] win_len;

    sbt_tier_lookup #(
        .STEP_W  (STEP_W),
        .STEP_MAX(STEP_MAX)
    ) u_lookup (
        .step_code (step_code),
        .torque_sel(torque_sel),
        .tier      (tier)
    );

    // Tier to window length in clock cycles
    always_comb begin
        unique case (tier)
            TIER_LONG:  win_len = CNT_W'(LEN_LONG);
            TIER_MID:   win_len = CNT_W'(LEN_MID);
            TIER_SHORT: win_len = CNT_W'(LEN_SHORT);
            TIER_MIN:   win_len = CNT_W'(LEN_MIN);
            default:    win_len = CNT_W'(LEN_MIN);
        endcase
    end

    sbt_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (drive_start),
        .sense       (sense_raw),
        .load_len    (win_len),
        .blank_active(blank_active),
        .trip        (trip_out)
    );

    // The comparator never reaches the output while the window is open
    assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blank_active |-> !trip_out);

    // A start pulse always opens the window on the next cycle
    assert_start_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_start |=> blank_active);

    // Without a drive phase, no trip is reported
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_out && !drive_start) |=> !trip_out);

endmodule

// File: tb/sim_sense_blank_timer.sv
module sim_sense_blank_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       drive_start;
    logic       sense_raw;
    logic [4:0] step_code;
    logic [1:0] torque_sel;
    logic       trip_out;
    logic       blank_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sense_blank_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .drive_start (drive_start),
        .sense_raw   (sense_raw),
        .step_code   (step_code),
        .torque_sel  (torque_sel),
        .trip_out    (trip_out),
        .blank_active(blank_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected window length, written from the requirement table
    function automatic int expect_len(input int s, input int t);
        int e;
        e = (s < 1) ? 1 : ((s > 16) ? 16 : s);
        case (t)
            0: begin
                if (e >= 9)      return 18;
                else if (e >= 5) return 15;
                else if (e >= 3) return 12;
                else             return 9;
            end
            1: begin
                if (e >= 5)      return 15;
                else if (e >= 3) return 12;
                else             return 9;
            end
            2: begin
                if (e >= 9)      return 15;
                else if (e >= 5) return 12;
                else             return 9;
            end
            default: return (e >= 9) ? 12 : 9;
        endcase
    endfunction

    function automatic string tq_req(input int t);
        case (t)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Pulse drive_start for one cycle, then scramble the codes (R9)
    task automatic pulse(input int s, input int t);
        @(negedge clk);
        step_code   = 5'(s);
        torque_sel  = 2'(t);
        drive_start = 1'b1;
        @(negedge clk);
        drive_start = 1'b0;
        step_code   = 5'd1;
        torque_sel  = 2'(3 - t);
    endtask

    // Count window cycles from the current negedge; sense_raw is held high
    task automatic measure(input int exp, input string req);
        int n = 0;
        while (blank_active && n < 40) begin
            chk(trip_out == 1'b0, "R3", trip_out, 0);
            n++;
            @(negedge clk);
        end
        chk(n == exp, req, n, exp);
        chk(trip_out == 1'b1, "R11", trip_out, 1);
        @(negedge clk);
        chk(trip_out == 1'b0 && blank_active == 1'b0, "R11", {trip_out, blank_active}, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        drive_start = 1'b0;
        sense_raw   = 1'b1;
        step_code   = 5'd16;
        torque_sel  = 2'd0;
        repeat (3) @(negedge clk);
        chk(blank_active == 1'b0 && trip_out == 1'b0, "R1", {blank_active, trip_out}, 0);
        rst_n = 1'b1;

        // R12: IDLE ignores a high comparator
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(trip_out == 1'b0, "R12", trip_out, 0);
        end

        // R2, R4..R8, R9: full sweep of step and torque codes
        for (int t = 0; t < 4; t++) begin
            for (int s = 0; s < 32; s++) begin
                pulse(s, t);
                measure(expect_len(s, t),
                        (s == 0 || s > 16) ? "R8" : ((s == 16) ? "R2" : tq_req(t)));
            end
        end

        // R10: a restart inside a long window takes the new, shorter length
        pulse(16, 0);
        repeat (4) @(negedge clk);
        chk(blank_active == 1'b1, "R10", blank_active, 1);
        pulse(1, 3);
        measure(9, "R10");

        // R10: a restart from ARMED opens a new window
        sense_raw = 1'b0;
        pulse(2, 0);
        repeat (12) @(negedge clk);
        chk(blank_active == 1'b0 && trip_out == 1'b0, "R11", {blank_active, trip_out}, 0);
        sense_raw = 1'b1;
        pulse(12, 1);
        measure(15, "R10");

        // R11: in ARMED the trip follows the comparator in the same cycle
        sense_raw = 1'b0;
        pulse(4, 2);
        repeat (12) @(negedge clk);
        chk(trip_out == 1'b0, "R11", trip_out, 0);
        sense_raw = 1'b1;
        #1;
        chk(trip_out == 1'b1, "R11", trip_out, 1);
        @(negedge clk);
        chk(trip_out == 1'b0, "R11", trip_out, 0);

        // R12: after returning to IDLE the comparator is ignored
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(trip_out == 1'b0 && blank_active == 1'b0, "R12", trip_out, 0);
        end

        // R1: reset in the middle of a window clears everything
        pulse(16, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(blank_active == 1'b0 && trip_out == 1'b0, "R1", {blank_active, trip_out}, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule